// File: doc/BRIEF.md
# ROM table lookup sequencer

This unit executes the table-read instruction of a small 4-bit controller. When it accepts the instruction, it builds a program-memory address. The page number from the instruction forms the high part. Bits 2..0 of register D followed by the four bits of register A form the low part. It then reads one 10-bit word through a synchronous ROM port. The low byte of that word is written to two nibble registers: the upper nibble goes to B and the lower nibble goes to A.

When the table mode flag is set, the unit also reloads register D. The two top bits of the ROM word go into D bits 1..0, and D bit 2 is cleared.

The ROM read borrows one return-stack level. The current program counter is pushed in the first cycle and popped back into the PC in the third. A push made while the stack pointer is at its top level raises an overflow strobe, and the push still goes ahead.

Instructions arrive on a valid/ready input. `ins_ready` is high only when the unit is idle. A word is taken on a clock edge where both `ins_valid` and `ins_ready` are high. While the unit is busy, upstream must hold the word and its valid flag. Register, PC and stack updates leave the unit as single-cycle write strobes with data, and the surrounding datapath owns the storage.

Top module: `tblrd_seq`

## Requirements
- R1: A word taken while bits 9..7 equal 3'b001 starts a lookup, and bits 6..0 are the page. A taken word with any other top bits is consumed without effect: no strobe rises and `ins_ready` stays high.
- R2: In the first cycle after a lookup is taken, `rom_en` is high and `rom_addr` = {page, D[2:0], A[3:0]} (page in bits 13..7). These are the register values sampled when the word was taken.
- R3: In that same first cycle, `stk_push` is high and `stk_wdata` equals `pc_in`. `stk_ovf` is high in that cycle exactly when `sp_in` is all ones.
- R4: In the second cycle, `b_we` and `a_we` are high, with `b_wdata` = ROM bits 7..4 and `a_wdata` = ROM bits 3..0.
- R5: If the mode flag was 1 when the word was taken, `d_we` is high in the second cycle with `d_wdata` = {0, ROM bit 9, ROM bit 8}. If it was 0, `d_we` stays low.
- R6: In the third cycle, `stk_pop`, `pc_we` and `done` are high, with `pc_wdata` equal to `stk_rdata`.
- R7: A lookup keeps `ins_ready` low for exactly three cycles. A new instruction can be taken in the cycle right after `done`.
- R8: After reset, the unit is idle with `ins_ready` high and every strobe low.
- R9: Every page value from 0 to 127 is accepted and appears unchanged in the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word valid |
| ins_ready | output | 1 | Unit idle, word can be taken |
| ins_word | input | 10 | Instruction word |
| mode_flag | input | 1 | Table mode flag, enables the D reload |
| reg_a | input | 4 | Current register A |
| reg_d | input | 3 | Current register D |
| pc_in | input | 14 | Current program counter |
| sp_in | input | 3 | Current stack pointer |
| stk_rdata | input | 14 | Stack entry at the current pointer |
| rom_data | input | 10 | ROM read data, one cycle after `rom_en` |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | 14 | ROM read address |
| stk_push | output | 1 | Push strobe (pointer up, then write) |
| stk_pop | output | 1 | Pop strobe (pointer down) |
| stk_wdata | output | 14 | Value to push |
| stk_ovf | output | 1 | Push made while the stack is full |
| a_we | output | 1 | Register A write strobe |
| a_wdata | output | 4 | Register A write data |
| b_we | output | 1 | Register B write strobe |
| b_wdata | output | 4 | Register B write data |
| d_we | output | 1 | Register D write strobe |
| d_wdata | output | 3 | Register D write data |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 14 | PC write data |
| done | output | 1 | Lookup complete pulse |

## Verification
The assertions assume that `stk_rdata` always shows the entry at the present stack pointer. They also assume that `rom_data` carries the word for the address presented with `rom_en` one cycle earlier. The bench meets both assumptions by modelling the stack, the ROM and the A/B/D/PC registers, and updating them only from the unit's strobes. It drives a new word only at a falling edge when `ins_ready` is high. It holds `mode_flag`, `reg_a` and `reg_d` steady around each accepted word.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_DATA = 2'd2,
    ST_POP  = 2'd3
  } tl_state_e;

  localparam int unsigned TL_OPC_W = 3;
  localparam logic [TL_OPC_W-1:0] TL_OPC = 3'b001;
endpackage

// File: rtl/tblrd_decode.sv
module tblrd_decode
  import tblrd_pkg::*;
#(
  parameter int unsigned INS_W  = 10,
  parameter int unsigned PAGE_W = 7
) (
  input  logic [INS_W-1:0]  ins_word,
  output logic              hit,
  output logic [PAGE_W-1:0] page
);
  assign hit  = (ins_word[INS_W-1 -: TL_OPC_W] == TL_OPC);
  assign page = ins_word[PAGE_W-1:0];
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ins_valid,
  input  logic      hit,
  output logic      ins_ready,
  output logic      start,
  output tl_state_e state
);
  tl_state_e nxt;

  assign ins_ready = (state == ST_IDLE);
  assign start     = ins_valid && ins_ready && hit;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = ST_PUSH;
      ST_PUSH: nxt = ST_DATA;
      ST_DATA: nxt = ST_POP;
      ST_POP:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/tblrd_unpack.sv
module tblrd_unpack #(
  parameter int unsigned ROM_W = 10,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned DLO_W = 3
) (
  input  logic [ROM_W-1:0] rom_data,
  output logic [NIB_W-1:0] hi_nib,
  output logic [NIB_W-1:0] lo_nib,
  output logic [DLO_W-1:0] d_val
);
  localparam int unsigned UP_W = ROM_W - 2*NIB_W;

  assign hi_nib = rom_data[2*NIB_W-1:NIB_W];
  assign lo_nib = rom_data[NIB_W-1:0];

  generate
    if (DLO_W > UP_W) begin : g_pad
      assign d_val = {{(DLO_W-UP_W){1'b0}}, rom_data[ROM_W-1:2*NIB_W]};
    end else begin : g_trim
      assign d_val = rom_data[2*NIB_W+DLO_W-1:2*NIB_W];
    end
  endgenerate
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
  import tblrd_pkg::*;
#(
  parameter int unsigned INS_W  = 10,
  parameter int unsigned PAGE_W = 7,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DLO_W  = 3,
  parameter int unsigned ROM_W  = 10,
  parameter int unsigned SP_W   = 3,
  localparam int unsigned PC_W  = PAGE_W + DLO_W + NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [INS_W-1:0]  ins_word,
  input  logic              mode_flag,
  input  logic [NIB_W-1:0]  reg_a,
  input  logic [DLO_W-1:0]  reg_d,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [PC_W-1:0]   stk_rdata,
  input  logic [ROM_W-1:0]  rom_data,
  output logic              rom_en,
  output logic [PC_W-1:0]   rom_addr,
  output logic              stk_push,
  output logic              stk_pop,
  output logic [PC_W-1:0]   stk_wdata,
  output logic              stk_ovf,
  output logic              a_we,
  output logic [NIB_W-1:0]  a_wdata,
  output logic              b_we,
  output logic [NIB_W-1:0]  b_wdata,
  output logic              d_we,
  output logic [DLO_W-1:0]  d_wdata,
  output logic              pc_we,
  output logic [PC_W-1:0]   pc_wdata,
  output logic              done
);
  localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};

  logic              hit, start, mode_q;
  logic [PAGE_W-1:0] page;
  logic [PC_W-1:0]   addr_q;
  tl_state_e         state;

  tblrd_decode #(.INS_W(INS_W), .PAGE_W(PAGE_W)) u_dec (
    .ins_word(ins_word), .hit(hit), .page(page)
  );

  tblrd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .hit(hit),
    .ins_ready(ins_ready), .start(start), .state(state)
  );

  tblrd_unpack #(.ROM_W(ROM_W), .NIB_W(NIB_W), .DLO_W(DLO_W)) u_unp (
    .rom_data(rom_data), .hi_nib(b_wdata), .lo_nib(a_wdata), .d_val(d_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      addr_q <= {page, reg_d, reg_a};
      mode_q <= mode_flag;
    end
  end

  assign rom_addr  = addr_q;
  assign rom_en    = (state == ST_PUSH);
  assign stk_push  = (state == ST_PUSH);
  assign stk_wdata = pc_in;
  assign stk_ovf   = stk_push && (sp_in == SP_TOP);
  assign a_we      = (state == ST_DATA);
  assign b_we      = (state == ST_DATA);
  assign d_we      = (state == ST_DATA) && mode_q;
  assign stk_pop   = (state == ST_POP);
  assign pc_we     = (state == ST_POP);
  assign pc_wdata  = stk_rdata;
  assign done      = (state == ST_POP);
endmodule

// File: rtl/tblrd_seq_chk.sv
module tblrd_seq_chk #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned DLO_W = 3,
  parameter int unsigned SP_W  = 3,
  parameter int unsigned PC_W  = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_ready,
  input logic [SP_W-1:0]  sp_in,
  input logic [PC_W-1:0]  stk_rdata,
  input logic             rom_en,
  input logic [PC_W-1:0]  rom_addr,
  input logic             stk_push,
  input logic             stk_pop,
  input logic             stk_ovf,
  input logic             a_we,
  input logic             b_we,
  input logic             d_we,
  input logic [DLO_W-1:0] d_wdata,
  input logic             pc_we,
  input logic [PC_W-1:0]  pc_wdata,
  input logic             done
);
  p_ovf_needs_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> stk_push);
  p_ovf_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && (sp_in == {SP_W{1'b1}})) |-> stk_ovf);
  p_rom_with_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |-> rom_en);
  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> $stable(rom_addr));
  p_split_after_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |-> (b_we && $past(stk_push)));
  p_dreload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> (a_we && !d_wdata[DLO_W-1]));
  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_pop |-> (pc_we && done && $past(a_we) && pc_wdata == stk_rdata));
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push || a_we || stk_pop) |-> !ins_ready);
  p_ready_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ins_ready);
endmodule

bind tblrd_seq tblrd_seq_chk #(.NIB_W(NIB_W), .DLO_W(DLO_W), .SP_W(SP_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/test_tblrd_seq.sv
module test_tblrd_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, mode_flag = 1'b0;
  logic [9:0] ins_word = '0;
  logic ins_ready, rom_en, stk_push, stk_pop, stk_ovf, a_we, b_we, d_we, pc_we, done;
  logic [13:0] rom_addr, stk_wdata, pc_wdata, stk_rdata;
  logic [3:0] a_wdata, b_wdata;
  logic [2:0] d_wdata;
  logic [9:0] rom_q = '0;

  logic [3:0]  m_a = '0, m_b = '0;
  logic [2:0]  m_d = '0, m_sp = '0;
  logic [13:0] m_pc = '0;
  logic [13:0] m_stk [8];

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tblrd_seq i_tblrd_seq (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .mode_flag(mode_flag), .reg_a(m_a), .reg_d(m_d),
    .pc_in(m_pc), .sp_in(m_sp), .stk_rdata(stk_rdata), .rom_data(rom_q),
    .rom_en(rom_en), .rom_addr(rom_addr), .stk_push(stk_push), .stk_pop(stk_pop),
    .stk_wdata(stk_wdata), .stk_ovf(stk_ovf), .a_we(a_we), .a_wdata(a_wdata),
    .b_we(b_we), .b_wdata(b_wdata), .d_we(d_we), .d_wdata(d_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .done(done)
  );

  function automatic logic [9:0] rom_f(input logic [13:0] ad);
    logic [13:0] t;
    t = ad * 14'd13 + (ad >> 3) + 14'd9;
    return t[9:0];
  endfunction

  assign stk_rdata = m_stk[m_sp];

  always @(posedge clk) begin
    if (rom_en) rom_q <= rom_f(rom_addr);
    if (a_we) m_a <= a_wdata;
    if (b_we) m_b <= b_wdata;
    if (d_we) m_d <= d_wdata;
    if (pc_we) m_pc <= pc_wdata;
    if (stk_push) begin
      m_stk[m_sp + 3'd1] <= stk_wdata;
      m_sp <= m_sp + 3'd1;
    end
    if (stk_pop) m_sp <= m_sp - 3'd1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Entered and left just after a falling edge with the unit idle.
  task automatic t_lookup(input logic [6:0] page, input logic [3:0] a, input logic [2:0] d,
                          input bit mode, input logic [2:0] sp, input logic [13:0] pc);
    logic [13:0] ea;
    logic [9:0]  w;
    ea = {page, d, a};
    w  = rom_f(ea);
    m_a = a; m_d = d; m_sp = sp; m_pc = pc; mode_flag = mode;
    ins_word = {3'b001, page}; ins_valid = 1'b1;
    chk(ins_ready == 1'b1, "R7 ready before take", ins_ready, 1);
    @(negedge clk);
    ins_valid = 1'b0; ins_word = '0;
    chk(rom_en && rom_addr == ea, "R2/R9 rom address", rom_addr, ea);
    chk(stk_push && stk_wdata == pc, "R3 push pc", stk_wdata, pc);
    chk(stk_ovf == (sp == 3'd7), "R3 overflow flag", stk_ovf, sp == 3'd7);
    chk(!ins_ready, "R7 busy cycle1", ins_ready, 0);
    @(negedge clk);
    chk(a_we && b_we && a_wdata == w[3:0] && b_wdata == w[7:4], "R4 nibble split",
        {b_wdata, a_wdata}, w[7:0]);
    chk(d_we == mode, "R5 d strobe", d_we, mode);
    if (mode) chk(d_wdata == {1'b0, w[9:8]}, "R5 d data", d_wdata, {1'b0, w[9:8]});
    chk(!ins_ready && !stk_push, "R7 busy cycle2", ins_ready, 0);
    @(negedge clk);
    chk(stk_pop && pc_we && done && pc_wdata == pc, "R6 restore pc", pc_wdata, pc);
    chk(!ins_ready, "R7 busy cycle3", ins_ready, 0);
    @(negedge clk);
    chk(ins_ready && !done, "R7 ready after done", ins_ready, 1);
    chk(m_b == w[7:4] && m_a == w[3:0], "R4 registers", {m_b, m_a}, w[7:0]);
    chk(m_d == (mode ? {1'b0, w[9:8]} : d), "R5 register d", m_d, mode ? {1'b0, w[9:8]} : d);
    chk(m_sp == sp && m_pc == pc, "R6 sp/pc back", {m_sp, m_pc}, {sp, pc});
  endtask

  task automatic t_other(input logic [9:0] word);
    m_a = 4'h5; m_b = 4'hA; m_pc = 14'h123; m_sp = 3'd2;
    ins_word = word; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0; ins_word = '0;
    chk(ins_ready && !rom_en && !stk_push, "R1 non-lookup ignored c1", stk_push, 0);
    @(negedge clk);
    chk(!a_we && !b_we && !d_we, "R1 non-lookup ignored c2", a_we, 0);
    @(negedge clk);
    chk(!stk_pop && !pc_we && !done, "R1 non-lookup ignored c3", done, 0);
    chk(m_a == 4'h5 && m_b == 4'hA && m_sp == 3'd2, "R1 regs untouched", {m_b, m_a}, 8'hA5);
  endtask

  task automatic t_reset();
    chk(ins_ready == 1'b1, "R8 ready after reset", ins_ready, 1);
    chk(!(rom_en || stk_push || stk_pop || a_we || b_we || d_we || pc_we || done || stk_ovf),
        "R8 strobes low", stk_push, 0);
  endtask

  initial begin
    foreach (m_stk[i]) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lookup(7'd0,   4'h3, 3'd1, 1'b0, 3'd1, 14'h0040);
    t_lookup(7'd127, 4'hF, 3'd7, 1'b1, 3'd0, 14'h3FFF);
    t_lookup(7'd47,  4'h9, 3'd5, 1'b1, 3'd3, 14'h1A2C);
    t_lookup(7'd31,  4'h0, 3'd2, 1'b0, 3'd7, 14'h0777);
    t_other(10'h1C5);
    t_other(10'h3FF);
    t_lookup(7'd64,  4'hC, 3'd4, 1'b1, 3'd6, 14'h2001);
    t_lookup(7'd65,  4'h1, 3'd0, 1'b0, 3'd6, 14'h2003);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule